// File: doc/BRIEF.md
# Lapped-Transform Post-FFT Combiner

This streaming stage sits behind a 2M-point FFT and turns its complex bins U(k) into complex lapped-transform coefficients X(k). Every bin entering the stage is rotated by a fixed complex modulation factor c(k) taken from an on-chip constant table, which gives V(k) = c(k)·U(k). Each coefficient is then formed from two neighbouring modulated bins as X(k) = j·V(k) + V(k+1). Only the first M coefficients are meaningful, so bins above index M are dropped.

The upstream FFT presents one bin per clock with its index and a valid strobe. A single pairing register keeps the previous V value, so a steady stream of bins yields one coefficient per clock. A block-start strobe separates blocks: it forgets any held or in-flight modulated bin, so that the last bins of one block are never paired with the first bin of the next. The default build has M = 128, 25-bit signed samples holding nine integer bits and fifteen fraction bits, and 16-bit Q15 factors.

Top module: `lapped_combiner`

## Requirements
- R1: While `rst` is high and after it, until the first coefficient, `coefValid` is 0 and `coefIdx`, `coefRe` and `coefIm` are all 0.
- R2: The factor for bin k (0 ≤ k ≤ M) is c(k) = exp(−j·(π(2k+1)/4 + πk/(2M))). Each part is multiplied by 32768, rounded to the nearest integer and clamped to the range −32768..32767.
- R3: Each part of V(k) is the exact complex product term (re: Ure·cre − Uim·cim, im: Ure·cim + Uim·cre), shifted right arithmetically by 15 bits. Only the low 25 bits are kept, as a signed value.
- R4: The coefficient for index k has real part −Vim(k) + Vre(k+1) and imaginary part Vre(k) + Vim(k+1), both taken modulo 2^25 as signed 25-bit values. It is presented with `coefIdx` = k.
- R5: If bin k+1 is sampled on clock edge t while V(k) is held, then `coefValid` is high after edge t+1 for that coefficient and is low after edge t.
- R6: A coefficient is emitted only when the newly sampled bin index is exactly one above the held bin index. Idle cycles in between do not disturb the held bin. An index that breaks the sequence emits nothing and becomes the new held bin.
- R7: Bins with index greater than M are ignored. A full block of 2M bins therefore yields exactly M coefficients, indices 0 to M−1.
- R8: When `blockStart` is high on an edge, the held bin and any bin still in the pipeline are discarded, and no coefficient is emitted on the next cycle. A bin sampled on that same edge is kept as the first bin of the new block.
- R9: A gap-free stream of consecutive bins produces coefficients on consecutive cycles with indices that increase by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| blockStart | input | 1 | Marks the start of a new block; clears pairing state |
| binValid | input | 1 | Bin inputs carry a valid FFT bin |
| binIdx | input | 8 | Index of the presented bin, 0..2M−1 |
| binRe | input | 25 | Bin real part, signed, 15 fraction bits |
| binIm | input | 25 | Bin imaginary part, signed, 15 fraction bits |
| coefValid | output | 1 | Coefficient outputs are valid this cycle |
| coefIdx | output | 7 | Index k of the presented coefficient |
| coefRe | output | 25 | Coefficient real part, signed, 15 fraction bits |
| coefIm | output | 25 | Coefficient imaginary part, signed, 15 fraction bits |

## Verification
Two actions can fall on the same clock edge: capturing a new bin and clearing the pairing state on `blockStart`. The bench sends bin 10, then raises `blockStart` together with bin 11, then sends bin 12. A correct block emits only the coefficient for index 11, computed from bins 11 and 12, and never pairs bins 10 and 11. In a second case, `blockStart` arrives with no bin while bin 20 is still in the pipeline, and the following bin 21 must produce no output. Together these cases separate "discard the old pair" from "keep the simultaneous bin".

// File: rtl/lapcomb_pkg.sv
package lapcomb_pkg;

  localparam real PI = 3.14159265358979323846;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadProd;  // register c(k)*U(k) of the incoming bin
    logic loadHold;  // move the registered product into the pairing register
    logic emit;      // form j*V(k)+V(k+1) into the output register
  } strobe_t;

  // Real value to signed fixed point with fracBits fraction bits, rounded and clamped
  function automatic int toFixed(real x, int fracBits);
    real scaled;
    int  r;
    int  hi;
    scaled = x * real'(1 << fracBits);
    r      = int'(scaled);
    hi     = (1 << fracBits) - 1;
    if (r > hi) r = hi;
    if (r < -(1 << fracBits)) r = -(1 << fracBits);
    return r;
  endfunction

endpackage

// File: rtl/lapcomb_ctrl.sv
module lapcomb_ctrl
  import lapcomb_pkg::*;
#(
  parameter int M      = 128,
  parameter int IDX_W  = $clog2(2 * M),
  parameter int CIDX_W = $clog2(M)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blockStart,
  input  logic              binValid,
  input  logic [IDX_W-1:0]  binIdx,
  output strobe_t           strobes,
  output logic              outValid,
  output logic [CIDX_W-1:0] outIdx
);

  localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(M);

  logic             accept;
  logic             s1Valid;
  logic [IDX_W-1:0] s1Idx;
  logic             holdValid;
  logic [IDX_W-1:0] holdIdx;

  assign accept = binValid && (binIdx <= LAST_BIN);

  always_comb begin
    strobes.loadProd = accept;
    strobes.loadHold = s1Valid && !blockStart;
    strobes.emit     = s1Valid && !blockStart && holdValid &&
                       (s1Idx == holdIdx + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid   <= 1'b0;
      s1Idx     <= '0;
      holdValid <= 1'b0;
      holdIdx   <= '0;
      outValid  <= 1'b0;
      outIdx    <= '0;
    end else begin
      s1Valid <= accept;
      if (accept) s1Idx <= binIdx;
      if (blockStart) begin
        holdValid <= 1'b0;
      end else if (s1Valid) begin
        holdValid <= 1'b1;
        holdIdx   <= s1Idx;
      end
      outValid <= strobes.emit;
      if (strobes.emit) outIdx <= holdIdx[CIDX_W-1:0];
    end
  end

  // R5: an output needs a bin sampled two edges earlier
  a_r5_two_stage_latency : assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(binValid, 2));

  // R8: block start suppresses the next output
  a_r8_start_blocks_emit : assert property (@(posedge clk) disable iff (rst)
    blockStart |=> !outValid);

  // R9: back-to-back outputs carry consecutive indices
  a_r9_consecutive_idx : assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(outValid)) |-> (outIdx == $past(outIdx) + 1'b1));

  // R7: a bin above M never enters the pipeline
  a_r7_high_bin_dropped : assert property (@(posedge clk) disable iff (rst)
    (binValid && (binIdx > LAST_BIN)) |=> !s1Valid);

endmodule

// File: rtl/lapcomb_datapath.sv
module lapcomb_datapath
  import lapcomb_pkg::*;
#(
  parameter int M      = 128,
  parameter int DATA_W = 25,
  parameter int COEF_W = 16,
  parameter int IDX_W  = $clog2(2 * M)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strobes,
  input  logic [IDX_W-1:0]         binIdx,
  input  logic signed [DATA_W-1:0] binRe,
  input  logic signed [DATA_W-1:0] binIm,
  output logic signed [DATA_W-1:0] coefRe,
  output logic signed [DATA_W-1:0] coefIm
);

  localparam int FRAC  = COEF_W - 1;
  localparam int PROD_W = DATA_W + COEF_W + 1;

  // Modulation factor table, computed at elaboration
  logic signed [COEF_W-1:0] romRe [M+1];
  logic signed [COEF_W-1:0] romIm [M+1];

  for (genvar k = 0; k <= M; k++) begin : g_rom
    localparam real ANG = -PI * (2.0 * real'(k) + 1.0) / 4.0
                          - PI * real'(k) / (2.0 * real'(M));
    localparam int FRE = toFixed($cos(ANG), FRAC);
    localparam int FIM = toFixed($sin(ANG), FRAC);
    assign romRe[k] = COEF_W'(FRE);
    assign romIm[k] = COEF_W'(FIM);
  end

  logic [IDX_W-1:0]         romIdx;
  logic signed [COEF_W-1:0] cRe, cIm;
  logic signed [PROD_W-1:0] pRe, pIm;
  logic signed [DATA_W-1:0] vRe, vIm, hRe, hIm;

  assign romIdx = (binIdx <= IDX_W'(M)) ? binIdx : '0;

  always_comb begin
    cRe = romRe[romIdx];
    cIm = romIm[romIdx];
    pRe = PROD_W'(binRe) * PROD_W'(cRe) - PROD_W'(binIm) * PROD_W'(cIm);
    pIm = PROD_W'(binRe) * PROD_W'(cIm) + PROD_W'(binIm) * PROD_W'(cRe);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vRe    <= '0;
      vIm    <= '0;
      hRe    <= '0;
      hIm    <= '0;
      coefRe <= '0;
      coefIm <= '0;
    end else begin
      if (strobes.loadProd) begin
        vRe <= pRe[FRAC +: DATA_W];
        vIm <= pIm[FRAC +: DATA_W];
      end
      if (strobes.loadHold) begin
        hRe <= vRe;
        hIm <= vIm;
      end
      if (strobes.emit) begin
        // j*V(k) is (-im, re); add V(k+1)
        coefRe <= vRe - hIm;
        coefIm <= vIm + hRe;
      end
    end
  end

  // R1: outputs only move when a coefficient is formed
  a_r1_out_quiet : assert property (@(posedge clk) disable iff (rst)
    !strobes.emit |=> $stable(coefRe) && $stable(coefIm));

endmodule

// File: rtl/lapped_combiner.sv
module lapped_combiner #(
  parameter int M      = 128,
  parameter int DATA_W = 25,
  parameter int COEF_W = 16,
  localparam int IDX_W  = $clog2(2 * M),
  localparam int CIDX_W = $clog2(M)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blockStart,
  input  logic              binValid,
  input  logic [IDX_W-1:0]  binIdx,
  input  logic [DATA_W-1:0] binRe,
  input  logic [DATA_W-1:0] binIm,
  output logic              coefValid,
  output logic [CIDX_W-1:0] coefIdx,
  output logic [DATA_W-1:0] coefRe,
  output logic [DATA_W-1:0] coefIm
);

  lapcomb_pkg::strobe_t strobes;
  logic signed [DATA_W-1:0] dRe, dIm;

  lapcomb_ctrl #(.M(M), .IDX_W(IDX_W), .CIDX_W(CIDX_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .blockStart(blockStart),
    .binValid  (binValid),
    .binIdx    (binIdx),
    .strobes   (strobes),
    .outValid  (coefValid),
    .outIdx    (coefIdx)
  );

  lapcomb_datapath #(.M(M), .DATA_W(DATA_W), .COEF_W(COEF_W), .IDX_W(IDX_W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .binIdx (binIdx),
    .binRe  ($signed(binRe)),
    .binIm  ($signed(binIm)),
    .coefRe (dRe),
    .coefIm (dIm)
  );

  assign coefRe = dRe;
  assign coefIm = dIm;

endmodule

// File: tb/lapped_combiner_tb_top.sv
module lapped_combiner_tb_top;

  localparam int  M   = 128;
  localparam int  DW  = 25;
  localparam int  IW  = 8;
  localparam int  CIW = 7;
  localparam real PI  = 3.14159265358979323846;

  // Stimulus table, walked cyclically over a full block (includes extremes to force wrap)
  localparam longint TAB_RE [8] = '{1000, -32768, 16777215, -16777216, 123456, 0, 5000000, -1};
  localparam longint TAB_IM [8] = '{2000, 32767, -16777216, -16777216, -654321, 0, 7, 1};

  logic clk = 1'b0, rst = 1'b1, blockStart = 1'b0, binValid = 1'b0;
  logic [IW-1:0]  binIdx = '0;
  logic [DW-1:0]  binRe = '0, binIm = '0;
  logic           coefValid;
  logic [CIW-1:0] coefIdx;
  logic [DW-1:0]  coefRe, coefIm;

  always #2 clk = ~clk;

  lapped_combiner dut_i (
    .clk(clk), .rst(rst), .blockStart(blockStart), .binValid(binValid),
    .binIdx(binIdx), .binRe(binRe), .binIm(binIm),
    .coefValid(coefValid), .coefIdx(coefIdx), .coefRe(coefRe), .coefIm(coefIm)
  );

  int     nChecks = 0, nFails = 0, gotCnt = 0, seqErr = 0, prevIdx = 0;
  bit     prevValid = 0, done = 0;
  bit     gotHit [M];
  longint gotRe [M], gotIm [M];
  longint drvRe [2*M], drvIm [2*M];

  function automatic longint w25(longint x);
    logic signed [24:0] t;
    t = x[24:0];
    return longint'(t);
  endfunction

  function automatic longint qc(int k, bit imPart);
    real a, s;
    int  r;
    a = -PI * (2.0 * k + 1.0) / 4.0 - PI * k / (2.0 * M);
    s = (imPart ? $sin(a) : $cos(a)) * 32768.0;
    r = int'(s);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return longint'(r);
  endfunction

  function automatic longint vPart(int k, bit imPart);
    longint p;
    p = imPart ? drvRe[k] * qc(k, 1) + drvIm[k] * qc(k, 0)
               : drvRe[k] * qc(k, 0) - drvIm[k] * qc(k, 1);
    return w25(p >>> 15);
  endfunction

  function automatic longint expRe(int k);
    return w25(-vPart(k, 1) + vPart(k + 1, 0));
  endfunction

  function automatic longint expIm(int k);
    return w25(vPart(k, 0) + vPart(k + 1, 1));
  endfunction

  // Output logger
  always @(negedge clk) begin
    if (rst) prevValid = 0;
    else begin
      if (coefValid) begin
        gotCnt++;
        gotHit[coefIdx] = 1;
        gotRe[coefIdx]  = longint'($signed(coefRe));
        gotIm[coefIdx]  = longint'($signed(coefIm));
        if (prevValid && int'(coefIdx) != prevIdx + 1) seqErr++;
        prevIdx = int'(coefIdx);
      end
      prevValid = coefValid;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(bit st, bit v, int idx, longint re, longint im);
    @(negedge clk);
    blockStart = st; binValid = v;
    binIdx = IW'(idx); binRe = DW'(re); binIm = DW'(im);
    if (v && idx < 2 * M) begin
      drvRe[idx] = w25(re);
      drvIm[idx] = w25(im);
    end
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, 0, 0);
  endtask

  task automatic clearLog();
    gotCnt = 0; seqErr = 0;
    for (int i = 0; i < M; i++) gotHit[i] = 0;
  endtask

  task automatic checkCoef(int k, string tag);
    chk(gotHit[k], {tag, " present"}, longint'(gotHit[k]), 1);
    chk(gotRe[k] == expRe(k), {tag, " real"}, gotRe[k], expRe(k));
    chk(gotIm[k] == expIm(k), {tag, " imag"}, gotIm[k], expIm(k));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(coefValid == 0, "R1 valid in reset", longint'(coefValid), 0);
    chk(coefRe == 0 && coefIm == 0 && coefIdx == 0, "R1 outputs in reset",
        longint'($signed(coefRe)), 0);
    rst = 1'b0;
    idle(2);
    chk(coefValid == 0, "R1 valid after reset", longint'(coefValid), 0);

    // R5 latency
    clearLog();
    drive(1, 1, 0, 40000, -70000);
    drive(0, 1, 1, -90000, 15000);
    drive(0, 0, 0, 0, 0);
    chk(coefValid == 0, "R5 not yet valid", longint'(coefValid), 0);
    drive(0, 0, 0, 0, 0);
    chk(coefValid == 1 && coefIdx == 0, "R5 valid on second edge", longint'(coefValid), 1);
    idle(2);
    checkCoef(0, "R4 first pair");

    // R2 factor table, unit bin followed by zero bin
    for (int t = 0; t < 3; t++) begin
      int k;
      k = (t == 0) ? 0 : (t == 1) ? 64 : M - 1;
      idle(2);
      clearLog();
      drive(1, 1, k, 32768, 0);
      drive(0, 1, k + 1, 0, 0);
      idle(3);
      chk(gotRe[k] == -qc(k, 1), "R2 factor imag via real out", gotRe[k], -qc(k, 1));
      chk(gotIm[k] == qc(k, 0), "R2 factor real via imag out", gotIm[k], qc(k, 0));
    end

    // R3 R4 R7 R9 full block from the stimulus table
    idle(3);
    clearLog();
    for (int k = 0; k < 2 * M; k++)
      drive(k == 0, 1, k, TAB_RE[k % 8], TAB_IM[k % 8]);
    idle(4);
    chk(gotCnt == M, "R7 count per block", gotCnt, M);
    chk(seqErr == 0, "R9 consecutive indices", seqErr, 0);
    for (int k = 0; k < M; k++) checkCoef(k, "R3 R4 block");

    // R6 idle gap keeps the held bin
    idle(3);
    clearLog();
    drive(1, 1, 30, 777777, -333);
    idle(3);
    drive(0, 1, 31, -4444444, 2222);
    idle(3);
    chk(gotCnt == 1, "R6 gap count", gotCnt, 1);
    checkCoef(30, "R6 gap");

    // R6 broken sequence
    clearLog();
    drive(0, 1, 40, 1111, 2222);
    drive(0, 1, 42, 3333, -4444);
    drive(0, 1, 43, -5555, 6666);
    idle(3);
    chk(gotCnt == 1, "R6 out-of-order count", gotCnt, 1);
    chk(!gotHit[40] && !gotHit[41], "R6 no pair across jump", longint'(gotHit[40]), 0);
    checkCoef(42, "R6 resume");

    // R8 start together with a bin
    clearLog();
    drive(0, 1, 10, 900000, 800000);
    drive(1, 1, 11, -700000, 600000);
    drive(0, 1, 12, 500000, -400000);
    idle(3);
    chk(!gotHit[10], "R8 no pair across start", longint'(gotHit[10]), 0);
    chk(gotCnt == 1, "R8 count", gotCnt, 1);
    checkCoef(11, "R8 first of new block");

    // R8 start alone flushes an in-flight bin
    clearLog();
    drive(0, 1, 20, 12345, 54321);
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 21, 11111, 22222);
    idle(3);
    chk(gotCnt == 0, "R8 flushed bin not paired", gotCnt, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule